// File: doc/BRIEF.md
# Arithmetic Flag and Condition-Code Unit

This block is the add/subtract datapath and condition-code register of a small processor core. Each cycle it can take one arithmetic operation: add, add with carry, subtract, subtract with borrow, negate or compare. The operation works on either the low byte or the full 16-bit word of its operands. The block returns the sized result at once, as a combinational output. On the next clock edge it loads the carry, overflow, zero, negative and half-carry flags into an 8-bit status register.

The same register holds an interrupt mask bit and two spare bits that software owns. Software can load the whole register with a direct write, and can read it at any time. A reset sets the mask bit, and so does interrupt entry. While the mask is set, the qualifier output for maskable interrupts is low. The qualifier does not gate the non-maskable interrupt; that interrupt is routed around this block.

Top module: `ccr_alu`

## Requirements
- R1: After reset the status register reads 8'h80: the mask bit (bit 7) is 1 and every other bit is 0.
- R2: When `csr_we` is high, all 8 bits of `csr_wdata` are loaded on the next edge. The bit layout is: 7 mask, 6 spare, 5 half-carry, 4 spare, 3 negative, 2 zero, 1 overflow, 0 carry. A direct write overrides any flag update in the same cycle.
- R3: When `irq_enter` is high, the mask bit is 1 after the next edge. This holds even if a direct write in the same cycle clears the bit.
- R4: `irq_ok` is high exactly when the mask bit is 0.
- R5: The operation codes are 0 add, 1 add with carry, 2 subtract (a-b), 3 subtract with borrow, 4 negate (0-a), 5 compare (a-b). With `is_word` low, only bits 7:0 of the operands are used, and `result[15:8]` is 0. `res_ok` is high when `op_valid` is high and the code is 0 to 4.
- R6: Carry is loaded with the carry out of the top bit for add operations. For subtract, negate and compare it is loaded with the borrow. Add with carry and subtract with borrow take the current carry flag as their carry or borrow input; the other codes ignore it.
- R7: Half-carry is loaded with the carry or borrow out of bit 3 for byte operations, and out of bit 11 for word operations.
- R8: Negative is loaded with the top bit of the sized result. Zero is set when the sized result is all zeros.
- R9: Overflow is set when the operation overflows as a two's-complement signed operation.
- R10: Compare updates the flags, and `res_ok` stays low.
- R11: The spare bits change only through a direct write. Codes 6 and 7, or `op_valid` low, leave the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 3 | Operation code (see R5) |
| is_word | input | 1 | 1 selects a 16-bit operation, 0 selects an 8-bit operation |
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand |
| result | output | 16 | Sized result, combinational |
| res_ok | output | 1 | The result is meant for writeback |
| csr_we | input | 1 | Direct write strobe for the status register |
| csr_wdata | input | 8 | Direct write data |
| irq_enter | input | 1 | Interrupt entry: sets the mask bit |
| csr_q | output | 8 | Status register contents |
| irq_ok | output | 1 | Maskable interrupts may be taken |

## Verification
The vector table runs each operation code at both sizes. It includes operand pairs chosen so that carry, half-carry, signed overflow and a zero result each occur alone. This tells a wrong nibble boundary (bit 3 against bit 11) apart from a wrong top-bit carry. It also tells a polarity error on the borrow apart from a wrong overflow term. Some vectors are preloaded with carry set, which shows whether the carry input reaches only add-with-carry and subtract-with-borrow. Byte vectors with non-zero upper bytes show that the upper bytes are ignored. Directed tests cover the ordering when a direct write meets a flag update or interrupt entry, and show that undefined codes are ignored.

// File: rtl/ccr_alu.sv
module ccr_alu (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [2:0]  op_code,
  input  logic        is_word,
  input  logic [15:0] opnd_a,
  input  logic [15:0] opnd_b,
  output logic [15:0] result,
  output logic        res_ok,
  input  logic        csr_we,
  input  logic [7:0]  csr_wdata,
  input  logic        irq_enter,
  output logic [7:0]  csr_q,
  output logic        irq_ok
);

  localparam logic [2:0] OP_ADD = 3'd0, OP_ADC = 3'd1, OP_SUB = 3'd2,
                         OP_SBB = 3'd3, OP_NEG = 3'd4, OP_CMP = 3'd5;

  logic [7:0]  ccr;
  logic        is_sub, known, c_in;
  logic [15:0] x, yy;
  logic [4:0]  nib;
  logic [12:0] lo12;
  logic [8:0]  b9;
  logic [16:0] w17;
  logic        f_h, f_n, f_z, f_v, f_c, xs, ys;

  assign known  = (op_code <= OP_CMP);
  assign is_sub = (op_code == OP_SUB) || (op_code == OP_SBB) ||
                  (op_code == OP_NEG) || (op_code == OP_CMP);
  assign x      = (op_code == OP_NEG) ? 16'h0000 : opnd_a;
  assign yy     = is_sub ? ~((op_code == OP_NEG) ? opnd_a : opnd_b) : opnd_b;
  assign c_in   = ((op_code == OP_ADC) || (op_code == OP_SBB)) ? (ccr[0] ^ is_sub) : is_sub;

  assign nib  = {1'b0, x[3:0]}  + {1'b0, yy[3:0]}  + {4'd0, c_in};
  assign lo12 = {1'b0, x[11:0]} + {1'b0, yy[11:0]} + {12'd0, c_in};
  assign b9   = {1'b0, x[7:0]}  + {1'b0, yy[7:0]}  + {8'd0, c_in};
  assign w17  = {1'b0, x}       + {1'b0, yy}       + {16'd0, c_in};

  assign result = is_word ? w17[15:0] : {8'h00, b9[7:0]};
  assign res_ok = op_valid && known && (op_code != OP_CMP);

  assign xs  = is_word ? x[15]  : x[7];
  assign ys  = is_word ? yy[15] : yy[7];
  assign f_n = is_word ? result[15] : result[7];
  assign f_z = is_word ? (result == 16'h0000) : (result[7:0] == 8'h00);
  assign f_v = (xs == ys) && (f_n != xs);
  assign f_h = (is_word ? lo12[12] : nib[4]) ^ is_sub;
  assign f_c = (is_word ? w17[16] : b9[8]) ^ is_sub;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccr <= 8'h80;
    end else begin
      if (csr_we)
        ccr <= csr_wdata;
      else if (op_valid && known) begin
        ccr[5] <= f_h;
        ccr[3] <= f_n;
        ccr[2] <= f_z;
        ccr[1] <= f_v;
        ccr[0] <= f_c;
      end
      if (irq_enter)
        ccr[7] <= 1'b1;
    end
  end

  assign csr_q  = ccr;
  assign irq_ok = ~ccr[7];

  p_reset_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (csr_q == 8'h80));

  p_write_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && !irq_enter) |=> (csr_q == $past(csr_wdata)));

  p_entry_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_enter |=> (csr_q[7] && !irq_ok));

  p_cmp_no_wb_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_CMP) |-> !res_ok);

  p_zero_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && known && !csr_we) |=>
      (csr_q[2] == ($past(is_word) ? ($past(result) == 16'h0000)
                                   : ($past(result[7:0]) == 8'h00))));

  p_spare_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_we |=> $stable({csr_q[6], csr_q[4]}));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!csr_we && !irq_enter && !(op_valid && known)) |=> $stable(csr_q));

endmodule

// File: tb/test_ccr_alu.sv
module test_ccr_alu;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [2:0]  op;
    logic        wd;
    logic [15:0] a;
    logic [15:0] b;
    logic        cin;
    logic [15:0] res;
    logic [4:0]  hnzvc;
  } vec_t;

  // flags column: {half-carry, negative, zero, overflow, carry}
  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 1'b0, 16'h003A, 16'h0026, 1'b0, 16'h0060, 5'b10000},
    '{3'd0, 1'b0, 16'h007F, 16'h0001, 1'b0, 16'h0080, 5'b11010},
    '{3'd0, 1'b0, 16'h00FF, 16'h0001, 1'b0, 16'h0000, 5'b10101},
    '{3'd1, 1'b0, 16'h0010, 16'h0020, 1'b1, 16'h0031, 5'b00000},
    '{3'd2, 1'b0, 16'h0010, 16'h0001, 1'b0, 16'h000F, 5'b10000},
    '{3'd2, 1'b0, 16'h0000, 16'h0001, 1'b0, 16'h00FF, 5'b11001},
    '{3'd2, 1'b0, 16'h0080, 16'h0001, 1'b0, 16'h007F, 5'b10010},
    '{3'd3, 1'b0, 16'h0005, 16'h0005, 1'b1, 16'h00FF, 5'b11001},
    '{3'd4, 1'b0, 16'h0001, 16'h0000, 1'b0, 16'h00FF, 5'b11001},
    '{3'd4, 1'b0, 16'h0080, 16'h0000, 1'b0, 16'h0080, 5'b01011},
    '{3'd4, 1'b0, 16'h0000, 16'h0000, 1'b1, 16'h0000, 5'b00100},
    '{3'd5, 1'b0, 16'h0042, 16'h0042, 1'b0, 16'h0000, 5'b00100},
    '{3'd0, 1'b1, 16'h0800, 16'h0800, 1'b0, 16'h1000, 5'b10000},
    '{3'd0, 1'b1, 16'h7FFF, 16'h0001, 1'b0, 16'h8000, 5'b11010},
    '{3'd2, 1'b1, 16'h0000, 16'h0001, 1'b0, 16'hFFFF, 5'b11001},
    '{3'd0, 1'b1, 16'hFFFF, 16'h0001, 1'b0, 16'h0000, 5'b10101},
    '{3'd5, 1'b1, 16'h1234, 16'h1235, 1'b0, 16'hFFFF, 5'b11001},
    '{3'd0, 1'b0, 16'hAB01, 16'hCD01, 1'b0, 16'h0002, 5'b00000},
    '{3'd3, 1'b1, 16'h1000, 16'h0000, 1'b1, 16'h0FFF, 5'b10000},
    '{3'd1, 1'b1, 16'hFFFF, 16'h0000, 1'b1, 16'h0000, 5'b10101},
    '{3'd0, 1'b0, 16'h0001, 16'h0001, 1'b1, 16'h0002, 5'b00000},
    '{3'd2, 1'b1, 16'h8000, 16'h0001, 1'b0, 16'h7FFF, 5'b10010}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic op_valid = 1'b0, is_word = 1'b0, csr_we = 1'b0, irq_enter = 1'b0;
  logic [2:0] op_code = 3'd0;
  logic [15:0] opnd_a = '0, opnd_b = '0;
  logic [7:0] csr_wdata = '0;
  logic [15:0] result;
  logic res_ok, irq_ok;
  logic [7:0] csr_q;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ccr_alu i_ccr_alu (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .is_word(is_word), .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
    .res_ok(res_ok), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .irq_enter(irq_enter), .csr_q(csr_q), .irq_ok(irq_ok));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic csr_write(input logic [7:0] d);
    @(negedge clk); csr_we = 1'b1; csr_wdata = d;
    @(negedge clk); csr_we = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset value", {8'h00, csr_q}, 16'h0080);
    chk("R4 masked after reset", {15'd0, irq_ok}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 held after release", {8'h00, csr_q}, 16'h0080);

    // R5 R6 R7 R8 R9 R10 vector walk; spare bits preloaded to 1 (R11)
    for (int i = 0; i < NV; i++) begin
      vec_t v = VEC[i];
      csr_write({8'h50 | {7'd0, v.cin}});
      @(negedge clk);
      op_valid = 1'b1; op_code = v.op; is_word = v.wd; opnd_a = v.a; opnd_b = v.b;
      #1;
      chk($sformatf("R5 result vec %0d", i), result, v.res);
      chk($sformatf("R5/R10 res_ok vec %0d", i), {15'd0, res_ok}, {15'd0, v.op != 3'd5});
      @(negedge clk);
      op_valid = 1'b0;
      chk($sformatf("R6/R7/R8/R9 flags vec %0d", i), {8'h00, csr_q},
          {8'h00, 8'h50 | {2'b00, v.hnzvc[4], 1'b0, v.hnzvc[3:0]}});
    end

    // R2 write loads all bits, R4 qualifier follows mask
    csr_write(8'h00);
    chk("R2 write zero", {8'h00, csr_q}, 16'h0000);
    chk("R4 unmasked", {15'd0, irq_ok}, 16'd1);
    csr_write(8'h7F);
    chk("R2 write 7F", {8'h00, csr_q}, 16'h007F);

    // R3 interrupt entry sets mask
    @(negedge clk); irq_enter = 1'b1;
    @(negedge clk); irq_enter = 1'b0;
    chk("R3 entry sets mask", {8'h00, csr_q}, 16'h00FF);
    chk("R4 masked after entry", {15'd0, irq_ok}, 16'd0);

    // R3 entry wins over write clearing the mask
    @(negedge clk); csr_we = 1'b1; csr_wdata = 8'h01; irq_enter = 1'b1;
    @(negedge clk); csr_we = 1'b0; irq_enter = 1'b0;
    chk("R3 entry beats write", {8'h00, csr_q}, 16'h0081);

    // R2 write beats a same-cycle flag update
    @(negedge clk); csr_we = 1'b1; csr_wdata = 8'h12;
    op_valid = 1'b1; op_code = 3'd0; is_word = 1'b0; opnd_a = 16'h00FF; opnd_b = 16'h0001;
    @(negedge clk); csr_we = 1'b0; op_valid = 1'b0;
    chk("R2 write beats flags", {8'h00, csr_q}, 16'h0012);

    // R11 undefined codes and idle leave register unchanged
    @(negedge clk); op_valid = 1'b1; op_code = 3'd6; opnd_a = 16'h0000; opnd_b = 16'h0000;
    #1 chk("R11 code 6 res_ok", {15'd0, res_ok}, 16'd0);
    @(negedge clk); op_code = 3'd7;
    @(negedge clk); op_valid = 1'b0; op_code = 3'd2; opnd_a = 16'h0000; opnd_b = 16'h0001;
    @(negedge clk);
    chk("R11 codes 6,7 and idle ignored", {8'h00, csr_q}, 16'h0012);
    chk("R5 idle res_ok low", {15'd0, res_ok}, 16'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule